// File: doc/BRIEF.md
# Operand Register-Number Latches

This block sits in the decode front end of a microcoded processor. It holds two 5-bit internal register numbers, called M and N, that the microcode uses whenever it refers to "the register named by the instruction" rather than to a fixed register. Each number is built from a 3-bit field of the instruction. Depending on the decode class, that field is expanded into a word register, a byte register or a segment register. Fixed codes can also be forced: the memory operand holder and the implied accumulator.

Loading takes two decode cycles. In the first-clock cycle, M is written with the word-register form of the opcode's low field, and N with the segment form of opcode bits 4..3. In the second-clock cycle, the addressing-mode byte and the decode-class flags may overwrite either latch. When nothing applies, both latches keep their value. The opcode must stay on its port through the second-clock cycle, because its W bit and bit 3 are still consulted then.

Top module: `regno_latch_unit`

## Requirements
- R1: While rst_n is low, both m_num and n_num read 0.
- R2: A cycle with first_clk=1 and second_clk=0 writes m_num = {1,1,opcode[2:0]}.
- R3: A cycle with first_clk=1 and second_clk=0 writes n_num = {0,0,0,opcode[4:3]}.
- R4: Byte mode holds when (has_wbit=1 and opcode[0]=0) or byte_only=1. On a second_clk cycle with has_modrm=1 and modebyte[7:6]=11, m_num takes the expanded form of modebyte[2:0]. The word form of a field f is {1,1,f}. The byte form is {f[2],~f[2],0,f[1:0]}.
- R5: On a second_clk cycle with has_modrm=1 and seg_field=0, n_num takes the byte or word form of modebyte[5:3], for every value of modebyte[7:6].
- R6: On a second_clk cycle with has_modrm=1 and seg_field=1, n_num = {0,0,0,modebyte[4:3]}.
- R7: On a second_clk cycle with has_modrm=1 and modebyte[7:6]≠11, m_num = 6 (the memory operand holder).
- R8: On a second_clk cycle with has_modrm=0 and acc_implied=1, m_num = {word,1,0,0,0}: 24 in word mode, 8 in byte mode.
- R9: On a second_clk cycle with has_modrm=0, acc_implied=0, imm_move=1 and opcode[3]=0, m_num changes from its held value {a,b,c,d,e} to {c,~c,0,d,e}. With opcode[3]=1, m_num is unchanged.
- R10: On a second_clk cycle with has_modrm=0, n_num is unchanged. It is also unchanged when acc_implied=0 and imm_move=0, and in that case m_num is unchanged as well.
- R11: A cycle with first_clk=0 and second_clk=0 leaves both latches unchanged, whatever the other inputs are.
- R12: When first_clk and second_clk are both 1, first_clk is ignored and only the second-clock rules apply.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| first_clk | input | 1 | First decode cycle strobe |
| second_clk | input | 1 | Second decode cycle strobe |
| opcode | input | 8 | Opcode byte, held through both decode cycles |
| modebyte | input | 8 | Addressing-mode byte (mod 7:6, reg 5:3, r/m 2:0) |
| has_wbit | input | 1 | Instruction carries a W bit in opcode[0] |
| byte_only | input | 1 | Instruction always operates on bytes |
| has_modrm | input | 1 | Instruction has an addressing-mode byte |
| seg_field | input | 1 | The reg field names a segment register |
| acc_implied | input | 1 | Accumulator is the implied operand |
| imm_move | input | 1 | Immediate move with byte/word selected by opcode[3] |
| m_num | output | 5 | M register number |
| n_num | output | 5 | N register number |

## Verification
The hardest case to reach from the ports is the byte conversion of R9. Its result depends on a value M received in an earlier cycle, so it can only be checked after a first-clock load, and it must be told apart from a conversion applied to a stale value. The stimulus therefore runs whole two-cycle instruction sequences: a random opcode is followed by a second cycle whose flags are biased toward the immediate-move and accumulator paths. Directed cases add the imm-move opcodes with bit 3 clear and set. Runs of idle cycles, second cycles without a first cycle, and overlapping strobes are mixed in so that the hold rules and the precedence rule are exercised with non-trivial held values.

// File: rtl/regno_pkg.sv
package regno_pkg;
  localparam int FIELD_W = 3;
  localparam int NUM_W   = 5;
  localparam int BANK_W  = NUM_W - FIELD_W;
  localparam int BYTE_W  = 8;

  typedef logic [FIELD_W-1:0] field_t;
  typedef logic [NUM_W-1:0]   regno_t;
  typedef logic [BYTE_W-1:0]  ibyte_t;

  typedef enum logic [1:0] {
    FORM_WORD = 2'd0,
    FORM_BYTE = 2'd1,
    FORM_SEG  = 2'd2
  } form_e;

  // Word registers live in the top bank.
  function automatic regno_t word_form(field_t f);
    return {{BANK_W{1'b1}}, f};
  endfunction

  // Byte halves line up with their word register: field MSB picks the half.
  function automatic regno_t byte_form(field_t f);
    return {f[FIELD_W-1], ~f[FIELD_W-1], 1'b0, f[FIELD_W-2:0]};
  endfunction

  // Segment registers occupy the lowest four codes.
  function automatic regno_t seg_form(field_t f);
    return {{(NUM_W-FIELD_W+1){1'b0}}, f[FIELD_W-2:0]};
  endfunction
endpackage

// File: rtl/regno_expand.sv
module regno_expand
  import regno_pkg::*;
(
  input  field_t field,
  input  form_e  kind,
  output regno_t num
);
  always_comb begin
    unique case (kind)
      FORM_BYTE: num = byte_form(field);
      FORM_SEG:  num = seg_form(field);
      default:   num = word_form(field);
    endcase
  end
endmodule

// File: rtl/regno_mode_dec.sv
module regno_mode_dec
  import regno_pkg::*;
(
  input  ibyte_t opcode,
  input  ibyte_t modebyte,
  input  logic   has_wbit,
  input  logic   byte_only,
  output logic   byte_mode,
  output logic   reg_direct,
  output field_t rm_field,
  output field_t reg_field,
  output field_t op_lo_field,
  output field_t op_mid_field,
  output logic   op_bit3
);
  localparam int MOD_HI = BYTE_W - 1;
  localparam int MOD_LO = BYTE_W - 2;

  logic unused_op_hi;
  assign unused_op_hi = ^opcode[BYTE_W-1:2*FIELD_W];

  always_comb begin
    byte_mode    = (has_wbit & ~opcode[0]) | byte_only;
    reg_direct   = &modebyte[MOD_HI:MOD_LO];
    rm_field     = modebyte[FIELD_W-1:0];
    reg_field    = modebyte[2*FIELD_W-1:FIELD_W];
    op_lo_field  = opcode[FIELD_W-1:0];
    op_mid_field = opcode[2*FIELD_W-1:FIELD_W];
    op_bit3      = opcode[FIELD_W];
  end
endmodule

// File: rtl/regno_m_next.sv
module regno_m_next
  import regno_pkg::*;
#(
  parameter regno_t OPR_NUM = 5'd6
) (
  input  logic   first_clk,
  input  logic   second_clk,
  input  logic   has_modrm,
  input  logic   acc_implied,
  input  logic   imm_move,
  input  logic   byte_mode,
  input  logic   reg_direct,
  input  logic   op_bit3,
  input  field_t op_lo_field,
  input  field_t rm_field,
  input  field_t m_lo,
  output regno_t m_d,
  output logic   m_en
);
  regno_t op_word_num;
  regno_t rm_num;
  regno_t acc_num;
  regno_t conv_num;
  form_e  rm_kind;

  assign rm_kind = byte_mode ? FORM_BYTE : FORM_WORD;

  regno_expand u_op_word (
    .field (op_lo_field),
    .kind  (FORM_WORD),
    .num   (op_word_num)
  );

  regno_expand u_rm (
    .field (rm_field),
    .kind  (rm_kind),
    .num   (rm_num)
  );

  always_comb begin
    acc_num  = {~byte_mode, 1'b1, {FIELD_W{1'b0}}};
    conv_num = byte_form(m_lo);
  end

  // Second clock outranks first clock; within it the mode byte wins.
  always_comb begin
    m_d  = op_word_num;
    m_en = 1'b0;
    if (second_clk) begin
      if (has_modrm) begin
        m_d  = reg_direct ? rm_num : OPR_NUM;
        m_en = 1'b1;
      end else if (acc_implied) begin
        m_d  = acc_num;
        m_en = 1'b1;
      end else if (imm_move && !op_bit3) begin
        m_d  = conv_num;
        m_en = 1'b1;
      end
    end else if (first_clk) begin
      m_d  = op_word_num;
      m_en = 1'b1;
    end
  end
endmodule

// File: rtl/regno_n_next.sv
module regno_n_next
  import regno_pkg::*;
(
  input  logic   first_clk,
  input  logic   second_clk,
  input  logic   has_modrm,
  input  logic   seg_field,
  input  logic   byte_mode,
  input  field_t op_mid_field,
  input  field_t reg_field,
  output regno_t n_d,
  output logic   n_en
);
  regno_t op_seg_num;
  regno_t reg_num;
  form_e  reg_kind;

  always_comb begin
    if (seg_field)      reg_kind = FORM_SEG;
    else if (byte_mode) reg_kind = FORM_BYTE;
    else                reg_kind = FORM_WORD;
  end

  regno_expand u_op_seg (
    .field (op_mid_field),
    .kind  (FORM_SEG),
    .num   (op_seg_num)
  );

  regno_expand u_reg (
    .field (reg_field),
    .kind  (reg_kind),
    .num   (reg_num)
  );

  always_comb begin
    n_d  = op_seg_num;
    n_en = 1'b0;
    if (second_clk) begin
      if (has_modrm) begin
        n_d  = reg_num;
        n_en = 1'b1;
      end
    end else if (first_clk) begin
      n_d  = op_seg_num;
      n_en = 1'b1;
    end
  end
endmodule

// File: rtl/regno_latch_unit.sv
module regno_latch_unit
  import regno_pkg::*;
#(
  parameter regno_t OPR_NUM = 5'd6
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         first_clk,
  input  logic         second_clk,
  input  logic [7:0]   opcode,
  input  logic [7:0]   modebyte,
  input  logic         has_wbit,
  input  logic         byte_only,
  input  logic         has_modrm,
  input  logic         seg_field,
  input  logic         acc_implied,
  input  logic         imm_move,
  output logic [4:0]   m_num,
  output logic [4:0]   n_num
);
  logic   byte_mode;
  logic   reg_direct;
  logic   op_bit3;
  field_t rm_field;
  field_t reg_field;
  field_t op_lo_field;
  field_t op_mid_field;
  regno_t m_q, m_d;
  regno_t n_q, n_d;
  logic   m_en, n_en;

  regno_mode_dec u_dec (
    .opcode       (opcode),
    .modebyte     (modebyte),
    .has_wbit     (has_wbit),
    .byte_only    (byte_only),
    .byte_mode    (byte_mode),
    .reg_direct   (reg_direct),
    .rm_field     (rm_field),
    .reg_field    (reg_field),
    .op_lo_field  (op_lo_field),
    .op_mid_field (op_mid_field),
    .op_bit3      (op_bit3)
  );

  regno_m_next #(.OPR_NUM(OPR_NUM)) u_m_next (
    .first_clk   (first_clk),
    .second_clk  (second_clk),
    .has_modrm   (has_modrm),
    .acc_implied (acc_implied),
    .imm_move    (imm_move),
    .byte_mode   (byte_mode),
    .reg_direct  (reg_direct),
    .op_bit3     (op_bit3),
    .op_lo_field (op_lo_field),
    .rm_field    (rm_field),
    .m_lo        (m_q[FIELD_W-1:0]),
    .m_d         (m_d),
    .m_en        (m_en)
  );

  regno_n_next u_n_next (
    .first_clk    (first_clk),
    .second_clk   (second_clk),
    .has_modrm    (has_modrm),
    .seg_field    (seg_field),
    .byte_mode    (byte_mode),
    .op_mid_field (op_mid_field),
    .reg_field    (reg_field),
    .n_d          (n_d),
    .n_en         (n_en)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)    m_q <= '0;
    else if (m_en) m_q <= m_d;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)    n_q <= '0;
    else if (n_en) n_q <= n_d;
  end

  assign m_num = m_q;
  assign n_num = n_q;
endmodule

// File: rtl/regno_latch_chk.sv
module regno_latch_chk (
  input logic       clk,
  input logic       rst_n,
  input logic       first_clk,
  input logic       second_clk,
  input logic [7:0] opcode,
  input logic [7:0] modebyte,
  input logic       has_modrm,
  input logic       seg_field,
  input logic       acc_implied,
  input logic [4:0] m_num,
  input logic [4:0] n_num
);
  always @(posedge clk) begin
    if (!rst_n) begin
      assert_reset_clear_R1: assert (m_num == 5'd0 && n_num == 5'd0);
    end
  end

  assert_first_m_word_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (first_clk && !second_clk) |=> (m_num == {2'b11, $past(opcode[2:0])}));

  assert_first_n_seg_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (first_clk && !second_clk) |=> (n_num == {3'b000, $past(opcode[4:3])}));

  assert_seg_move_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (second_clk && has_modrm && seg_field) |=> (n_num == {3'b000, $past(modebyte[4:3])}));

  assert_mem_opr_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (second_clk && has_modrm && modebyte[7:6] != 2'b11) |=> (m_num == 5'd6));

  assert_acc_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (second_clk && !has_modrm && acc_implied) |=> (m_num[3:0] == 4'b1000));

  assert_n_hold_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (second_clk && !has_modrm) |=> $stable(n_num));

  assert_idle_hold_R11: assert property (@(posedge clk) disable iff (!rst_n)
    (!first_clk && !second_clk) |=> ($stable(m_num) && $stable(n_num)));
endmodule

bind regno_latch_unit regno_latch_chk i_regno_latch_chk (
  .clk         (clk),
  .rst_n       (rst_n),
  .first_clk   (first_clk),
  .second_clk  (second_clk),
  .opcode      (opcode),
  .modebyte    (modebyte),
  .has_modrm   (has_modrm),
  .seg_field   (seg_field),
  .acc_implied (acc_implied),
  .m_num       (m_num),
  .n_num       (n_num)
);

// File: tb/test_regno_latch_unit.sv
module test_regno_latch_unit;
  timeunit 1ns;
  timeprecision 1ps;

  logic       clk = 1'b0;
  logic       rst_n = 1'b1;
  logic       first_clk = 1'b0, second_clk = 1'b0;
  logic [7:0] opcode = 8'h00, modebyte = 8'h00;
  logic       has_wbit = 1'b0, byte_only = 1'b0, has_modrm = 1'b0;
  logic       seg_field = 1'b0, acc_implied = 1'b0, imm_move = 1'b0;
  logic [4:0] m_num, n_num;

  int n_checks = 0;
  int n_fails  = 0;
  bit finished = 1'b0;
  logic [4:0] exp_m = 5'd0, exp_n = 5'd0;

  always #2 clk = ~clk;

  regno_latch_unit i_regno_latch_unit (
    .clk(clk), .rst_n(rst_n), .first_clk(first_clk), .second_clk(second_clk),
    .opcode(opcode), .modebyte(modebyte), .has_wbit(has_wbit),
    .byte_only(byte_only), .has_modrm(has_modrm), .seg_field(seg_field),
    .acc_implied(acc_implied), .imm_move(imm_move),
    .m_num(m_num), .n_num(n_num)
  );

  function automatic logic [4:0] wf(logic [2:0] f);
    return {2'b11, f};
  endfunction

  function automatic logic [4:0] bf(logic [2:0] f);
    return {f[2], ~f[2], 1'b0, f[1:0]};
  endfunction

  task automatic check(string tag, logic [4:0] em, logic [4:0] en);
    n_checks++;
    if (m_num !== em || n_num !== en) begin
      n_fails++;
      $display("FAIL %s: m=%0d n=%0d expected m=%0d n=%0d", tag, m_num, n_num, em, en);
    end
  endtask

  // One clock of stimulus; expected values follow the requirements.
  task automatic step(logic f1, logic f2, logic [7:0] op, logic [7:0] mb,
                      logic hw, logic bo, logic mr, logic sf, logic ai, logic im);
    logic bm, rd;
    logic [4:0] nm, nn;
    string tag;
    first_clk = f1; second_clk = f2; opcode = op; modebyte = mb;
    has_wbit = hw; byte_only = bo; has_modrm = mr; seg_field = sf;
    acc_implied = ai; imm_move = im;
    bm = (hw & ~op[0]) | bo;
    rd = (mb[7:6] == 2'b11);
    nm = exp_m; nn = exp_n;
    if (f2) begin
      if (mr) begin
        nm  = rd ? (bm ? bf(mb[2:0]) : wf(mb[2:0])) : 5'd6;
        nn  = sf ? {3'b000, mb[4:3]} : (bm ? bf(mb[5:3]) : wf(mb[5:3]));
        tag = {rd ? "R4" : "R7", sf ? " R6" : " R5"};
      end else if (ai) begin
        nm  = {~bm, 4'b1000};
        tag = "R8 R10";
      end else if (im) begin
        if (!op[3]) nm = bf(exp_m[2:0]);
        tag = "R9 R10";
      end else begin
        tag = "R10";
      end
      if (f1) tag = {"R12 ", tag};
    end else if (f1) begin
      nm  = wf(op[2:0]);
      nn  = {3'b000, op[4:3]};
      tag = "R2 R3";
    end else begin
      tag = "R11";
    end
    @(posedge clk);
    exp_m = nm; exp_n = nn;
    @(negedge clk);
    check(tag, exp_m, exp_n);
  endtask

  task automatic idle(logic [7:0] op, logic [7:0] mb);
    step(1'b0, 1'b0, op, mb, 1'b1, 1'b1, 1'b1, 1'b1, 1'b1, 1'b1);
  endtask

  task automatic do_reset();
    rst_n = 1'b0;
    #1;
    exp_m = 5'd0; exp_n = 5'd0;
    check("R1", 5'd0, 5'd0);
    @(negedge clk);
    check("R1", 5'd0, 5'd0);
    rst_n = 1'b1;
  endtask

  initial begin
    #1 rst_n = 1'b0;
    exp_m = 5'd0; exp_n = 5'd0;
    @(negedge clk);
    @(negedge clk);
    check("R1", 5'd0, 5'd0);
    rst_n = 1'b1;
    void'($urandom(32'd20240611));

    // Word register-to-register with mode byte: M=24, N=27
    step(1, 0, 8'h29, 8'h00, 0, 0, 0, 0, 0, 0);
    check("R2 R3", 5'd25, 5'd1);
    step(0, 1, 8'h29, 8'hD8, 1, 0, 1, 0, 0, 0);
    check("R4 R5", 5'd24, 5'd27);
    idle(8'hFF, 8'hFF);
    // Byte forms: N=16, M=11
    step(1, 0, 8'h28, 8'h00, 0, 0, 0, 0, 0, 0);
    step(0, 1, 8'h28, 8'hE3, 1, 0, 1, 0, 0, 0);
    check("R4 R5", 5'd11, 5'd16);
    // Memory operand: M=6, N still from reg
    step(1, 0, 8'h01, 8'h00, 0, 0, 0, 0, 0, 0);
    step(0, 1, 8'h01, 8'h47, 1, 0, 1, 0, 0, 0);
    check("R7 R5", 5'd6, 5'd24);
    // Accumulator byte then word
    step(1, 0, 8'h04, 8'h00, 0, 0, 0, 0, 0, 0);
    step(0, 1, 8'h04, 8'hFF, 1, 0, 0, 0, 1, 0);
    check("R8", 5'd8, 5'd0);
    step(1, 0, 8'h05, 8'h00, 0, 0, 0, 0, 0, 0);
    step(0, 1, 8'h05, 8'hFF, 1, 0, 0, 0, 1, 0);
    check("R8", 5'd24, 5'd0);
    // Immediate move, bit3 clear converts 27 to 11; bit3 set keeps 27
    step(1, 0, 8'hB3, 8'h00, 0, 0, 0, 0, 0, 0);
    check("R2", 5'd27, 5'd2);
    step(0, 1, 8'hB3, 8'h00, 0, 0, 0, 0, 0, 1);
    check("R9", 5'd11, 5'd2);
    step(1, 0, 8'hBB, 8'h00, 0, 0, 0, 0, 0, 0);
    step(0, 1, 8'hBB, 8'h00, 0, 0, 0, 0, 0, 1);
    check("R9", 5'd27, 5'd3);
    // Segment push then a plain second clock: hold
    step(1, 0, 8'h1E, 8'h00, 0, 0, 0, 0, 0, 0);
    step(0, 1, 8'h1E, 8'hD8, 0, 0, 0, 0, 0, 0);
    check("R3 R10", 5'd30, 5'd3);
    // Segment register move
    step(1, 0, 8'h8E, 8'h00, 0, 0, 0, 0, 0, 0);
    step(0, 1, 8'h8E, 8'hD0, 0, 0, 1, 1, 0, 0);
    check("R6", 5'd24, 5'd2);
    // Byte-only class
    step(1, 0, 8'hD7, 8'h00, 0, 0, 0, 0, 0, 0);
    step(0, 1, 8'hD7, 8'hC9, 0, 1, 1, 0, 0, 0);
    check("R4 R5", 5'd9, 5'd9);
    // Both strobes: first ignored
    step(1, 1, 8'h07, 8'h00, 1, 0, 0, 0, 1, 0);
    check("R12", 5'd24, 5'd9);
    idle(8'h00, 8'h00);
    check("R11", 5'd24, 5'd9);
    do_reset();

    for (int i = 0; i < 600; i++) begin
      logic [7:0] op, mb;
      logic [3:0] pick;
      op = 8'($urandom);
      mb = 8'($urandom);
      pick = 4'($urandom);
      if (pick != 4'd0)
        step(1, 0, op, 8'($urandom), 1'($urandom), 1'($urandom), 1'($urandom),
             1'($urandom), 1'($urandom), 1'($urandom));
      if (pick == 4'd5) idle(op, mb);
      begin
        logic mr, ai, im;
        mr = ($urandom % 3) == 0;
        ai = ($urandom % 3) == 0;
        im = ($urandom % 2) == 0;
        step(pick == 4'd7, 1, op, mb, 1'($urandom), ($urandom % 4) == 0, mr,
             ($urandom % 4) == 0, ai, im);
      end
      if (pick == 4'd9) idle(8'($urandom), 8'($urandom));
      if (i == 300) do_reset();
    end

    finished = 1'b1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_checks, n_fails);
    $finish;
  end

  initial begin
    #(200000 * 4);
    if (!finished) begin
      n_checks++;
      n_fails++;
      $display("FAIL watchdog: run did not finish, actual=hung expected=done");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_checks, n_fails);
      $finish;
    end
  end
endmodule